// File: doc/BRIEF.md
# Snapshot-Read 64-bit Free-Running Counter

This block keeps a 64-bit up counter that advances by one on every clock cycle in which a synchronous tick enable is high. Software cannot read the live counter directly over a 32-bit register bus. A 32-bit read of one half while the other half carries would give a torn value. Software instead asks for a snapshot. It writes a request bit in the control register. A fixed number of clock cycles later the hardware copies the live counter into a 64-bit shadow register and drops the request bit.

Software polls the request bit until it reads zero. It then reads the two shadow halves in either order. Both halves always belong to the same snapshot, because the shadow changes only at a capture. The live counter keeps running throughout.

Top module: `latched_counter`

## Requirements
- R1: A synchronous active-low reset clears the live counter, the shadow register and the request bit, so every register read returns 0 after reset. This includes a request that was still pending when reset arrived.
- R2: The live counter increases by exactly one on each rising clock edge at which `tick_en` is 1. It holds its value on edges at which `tick_en` is 0.
- R3: A write to offset 0xA0 with bit 1 (value 0x02) set starts a snapshot when none is pending. From the next cycle that register reads 0x00000002 until the capture.
- R4: The capture happens on the third rising edge after the write edge. The shadow takes the value the live counter held just before that edge, and on that same edge the request bit returns to 0.
- R5: Offset 0xA4 reads shadow bits 31:0 and offset 0xA8 reads shadow bits 63:32. Between captures the shadow is stable, so the two halves come from one snapshot whatever order and spacing software uses to read them.
- R6: The live counter keeps counting while a snapshot is pending, and later snapshots show that progress.
- R7: A write to 0xA0 with bit 1 clear has no effect. The request bit stays 0 and the shadow keeps its value.
- R8: A request written while one is pending is absorbed into it. The capture still happens on the third edge after the first request, and there is no second capture.
- R9: The counter wraps from all ones to zero. This is shown with a narrow `CNT_W` instance whose unused upper shadow bits read as 0.
- R10: Control register bits other than bit 1 read as 0. Reads of any offset other than 0xA0, 0xA4 and 0xA8 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable, one increment per cycle when high |
| bus_addr | input | ADDR_W (8) | Register byte offset for reads and writes |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The bench samples the request bit and the shadow at each cycle around a request. A design that captured one cycle early or late, or that cleared the bit on the wrong edge, would show a snapshot off by one tick count or a request bit of the wrong value. It reads the high word, waits, and then reads the low word while the counter moves under a gated tick pattern. A shadow that followed the live counter would give mismatched halves. It also covers a repeated request during a pending one, which a design might let restart the delay. Further cases are writes with bit 1 clear, and a reset that lands in the middle of a request. A wrap test runs a 10-bit instance past all ones, which a saturating or mis-sized counter would fail.

// File: rtl/lcnt_pkg.sv
// Shared constants for the snapshot counter: register offsets and the
// position of the request bit within the control register.
package lcnt_pkg;
    localparam int BUS_W = 32;
    localparam logic [7:0] OFS_CTRL = 8'hA0;
    localparam logic [7:0] OFS_LO   = 8'hA4;
    localparam logic [7:0] OFS_HI   = 8'hA8;
    localparam int REQ_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LO,
        SEL_HI
    } lcnt_sel_e;
endpackage

// File: rtl/lcnt_live.sv
// Live up counter. Advances by one per clock while tick_en is high and
// wraps naturally at 2**CNT_W. Assumes tick_en is synchronous to clk.
module lcnt_live #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    // Increment on enabled ticks, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (tick_en) count <= count + 1'b1;
    end

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count == $past(count) + 1'b1);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> count == '0);
endmodule

// File: rtl/lcnt_req.sv
// Snapshot request sequencer. A request starts a countdown of DELAY edges;
// capture is high in the last cycle, and busy drops on that edge.
// Requests while busy are absorbed. Assumes DELAY >= 1.
module lcnt_req #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    output logic busy,
    output logic capture
);
    localparam int DW = $clog2(DELAY + 1);

    logic [DW-1:0] dly;

    assign capture = busy && (dly == '0);

    // Start, count down, and finish a snapshot request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            dly  <= '0;
        end else if (!busy) begin
            if (req_wr) begin
                busy <= 1'b1;
                dly  <= DW'(DELAY - 1);
            end
        end else if (dly == '0) begin
            busy <= 1'b0;
        end else begin
            dly <= dly - 1'b1;
        end
    end

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_wr |=> busy && dly == DW'(DELAY - 1));
    a_r3_stays_pending: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !capture |=> busy);
    a_r4_clears_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !busy);
    a_r8_absorb_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_wr && dly != '0 |=> dly == $past(dly) - 1'b1);
endmodule

// File: rtl/lcnt_shadow.sv
// Shadow register. Loads the live count on capture, otherwise holds.
module lcnt_shadow #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] shadow
);
    // Take a coherent copy of the live counter on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow <= '0;
        else if (capture) shadow <= live;
    end

    a_r5_stable_between: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(shadow));
    a_r4_takes_live: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> shadow == $past(live));
endmodule

// File: rtl/latched_counter.sv
// Top: free-running counter read through a request/capture snapshot.
// Register bus: write strobe sampled at the clock edge, read data
// combinational from bus_addr. CNT_W must be between 2 and 2*BUS_W.
module latched_counter #(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8,
    parameter int DELAY  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    import lcnt_pkg::*;

    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] shadow_q;
    logic             busy;
    logic             capture;
    logic             req_wr;
    logic [BUS_W-1:0] lo_word;
    logic [BUS_W-1:0] hi_word;
    lcnt_sel_e        sel;

    assign req_wr = bus_we && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[REQ_BIT];

    lcnt_live #(.CNT_W(CNT_W)) u_live (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(live_q)
    );

    lcnt_req #(.DELAY(DELAY)) u_req (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .busy(busy), .capture(capture)
    );

    lcnt_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .capture(capture), .live(live_q), .shadow(shadow_q)
    );

    // Split the shadow into bus words, zero-extending a narrow counter.
    generate
        if (CNT_W > BUS_W) begin : g_wide
            assign lo_word = shadow_q[BUS_W-1:0];
            assign hi_word = BUS_W'(shadow_q[CNT_W-1:BUS_W]);
        end else begin : g_narrow
            assign lo_word = BUS_W'(shadow_q);
            assign hi_word = '0;
        end
    endgenerate

    // Decode the read offset.
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_CTRL))    sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFS_LO)) sel = SEL_LO;
        else if (bus_addr == ADDR_W'(OFS_HI)) sel = SEL_HI;
        else                                  sel = SEL_NONE;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: bus_rdata[REQ_BIT] = busy;
            SEL_LO:   bus_rdata = lo_word;
            SEL_HI:   bus_rdata = hi_word;
            default:  bus_rdata = '0;
        endcase
    end

    a_r7_zero_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && bus_we && !bus_wdata[REQ_BIT] |=> !busy);
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !busy && shadow_q == '0);
endmodule

// File: tb/tb_latched_counter.sv
module tb_latched_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] rdata_w;

    int errors = 0;
    int checks = 0;
    int tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [63:0] model = '0;
    logic [63:0] last_snap = '0;

    always #10 clk = ~clk;

    latched_counter dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    latched_counter #(.CNT_W(10)) dut_w (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata_w)
    );

    // Arithmetic model of the live count.
    always @(posedge clk) begin
        if (!rst_n)       model <= '0;
        else if (tick_en) model <= model + 64'd1;
    end

    // Tick pattern generator, driven away from the active edge.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tick_mode)
            0: tick_en <= 1'b0;
            1: tick_en <= 1'b1;
            2: tick_en <= ~tick_en;
            default: tick_en <= lfsr[0];
        endcase
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Full request/poll/read sequence with cycle-exact expectations.
    task automatic snap(input string req);
        logic [31:0] v, hi, lo;
        logic [63:0] exp;
        wr(8'hA0, 32'h2);
        rd(8'hA0, v); check("R3 pending", {32'd0, v}, 64'h2);
        @(negedge clk);
        @(negedge clk);
        exp = model;
        rd(8'hA0, v); check("R3 still pending", {32'd0, v}, 64'h2);
        @(negedge clk);
        rd(8'hA0, v); check("R4 cleared", {32'd0, v}, 64'h0);
        rd(8'hA8, hi);
        rd(8'hA4, lo);
        check(req, {hi, lo}, exp);
        last_snap = exp;
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, hi, lo;
        logic [63:0] exp, first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'hA0, v); check("R1 ctrl", {32'd0, v}, 0);
        rd(8'hA4, v); check("R1 lo", {32'd0, v}, 0);
        rd(8'hA8, v); check("R1 hi", {32'd0, v}, 0);
        // R2 R4 R5 running counter
        tick_mode = 1;
        repeat (20) @(negedge clk);
        snap("R4 R2 snapshot value");
        first = last_snap;
        // R5: high first, wait, then low while counter moves
        rd(8'hA8, hi);
        repeat (7) @(negedge clk);
        rd(8'hA4, lo);
        check("R5 halves coherent", {hi, lo}, last_snap);
        // R6: later snapshot shows progress
        snap("R6 second snapshot");
        check("R6 progressed", {63'd0, last_snap > first}, 64'd1);
        // R2 hold with tick off
        tick_mode = 0;
        @(negedge clk);
        snap("R2 hold snap A");
        exp = last_snap;
        repeat (10) @(negedge clk);
        snap("R2 hold snap B");
        check("R2 no change when idle", last_snap, exp);
        // R2 gated patterns
        tick_mode = 2;
        for (int i = 0; i < 5; i++) begin
            repeat (i + 3) @(negedge clk);
            snap("R2 alternating ticks");
        end
        tick_mode = 3;
        for (int i = 0; i < 8; i++) begin
            repeat (i * 2 + 1) @(negedge clk);
            snap("R2 irregular ticks");
        end
        // R7: write of zero does nothing
        tick_mode = 1;
        wr(8'hA0, 32'h0);
        rd(8'hA0, v); check("R7 ctrl stays 0", {32'd0, v}, 0);
        repeat (5) @(negedge clk);
        rd(8'hA8, hi); rd(8'hA4, lo);
        check("R7 shadow unchanged", {hi, lo}, last_snap);
        // R10: other ctrl bits
        wr(8'hA0, 32'hFFFF_FFFD);
        rd(8'hA0, v); check("R10 other bits ignored", {32'd0, v}, 0);
        repeat (4) @(negedge clk);
        rd(8'hA4, lo); check("R7 shadow after masked write", {32'd0, lo}, {32'd0, last_snap[31:0]});
        rd(8'hB0, v); check("R10 unmapped", {32'd0, v}, 0);
        rd(8'h00, v); check("R10 unmapped zero", {32'd0, v}, 0);
        // R8: request while pending
        wr(8'hA0, 32'h2);
        wr(8'hA0, 32'h2);
        rd(8'hA0, v); check("R8 pending", {32'd0, v}, 64'h2);
        @(negedge clk);
        exp = model;
        @(negedge clk);
        rd(8'hA0, v); check("R8 clears on original schedule", {32'd0, v}, 0);
        rd(8'hA4, lo); rd(8'hA8, hi);
        check("R8 snapshot from first request", {hi, lo}, exp);
        repeat (6) @(negedge clk);
        rd(8'hA0, v); check("R8 no second capture ctrl", {32'd0, v}, 0);
        rd(8'hA4, lo); rd(8'hA8, hi);
        check("R8 no second capture", {hi, lo}, exp);
        // R9 wrap on narrow instance
        repeat (1100) @(negedge clk);
        snap("R9 wide snapshot");
        check("R9 past wrap", {63'd0, last_snap > 64'd1023}, 64'd1);
        bus_addr = 8'hA4; #1;
        check("R9 narrow wraps", {32'd0, rdata_w}, {54'd0, last_snap[9:0]});
        bus_addr = 8'hA8; #1;
        check("R9 narrow hi zero", {32'd0, rdata_w}, 0);
        // R1: reset during pending request
        wr(8'hA0, 32'h2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        tick_mode = 0;
        rd(8'hA0, v); check("R1 pending dropped", {32'd0, v}, 0);
        repeat (4) @(negedge clk);
        rd(8'hA0, v); check("R1 no late capture", {32'd0, v}, 0);
        rd(8'hA4, lo); rd(8'hA8, hi);
        check("R1 shadow cleared", {hi, lo}, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule